// File: doc/BRIEF.md
# Colour Palette with Packed Pixel Output

This block holds a 256-entry colour lookup palette. Each entry has three 8-bit components: red, green and blue. Software programs the palette through a small write-only register port. One register word selects the entry to program. The other register word takes the components one after another, red first, then green, then blue. After the blue write, the entry pointer moves on by itself, so a whole palette can be loaded as a single stream of component writes.

On the display side, an 8-bit pixel index looks up an entry combinationally. The entry is returned packed into the pixel format the frame buffer host uses. The format is chosen by a depth selector and an optional swap of the red and blue fields. Every stored component raises a one-cycle invalidate pulse, which tells the display logic to redraw the whole screen.

Top module: `pal_lut_top`

## Requirements
- R1: A write to register word 0 sets the entry pointer to regWrData[31:24] and returns the component phase to red.
- R2: A write to register word 1 stores regWrData[31:24] into one component of the pointed entry. Successive word-1 writes fill red, then green, then blue. Data bits 23:0 are not used.
- R3: The word-1 write that stores blue also moves the entry pointer to (pointer+1) mod 256 and returns the phase to red, so entry 255 is followed by entry 0.
- R4: With depthSel=0, pixOut = {24'b0, R[7:5], G[7:5], B[7:6]}, and bgrOrder has no effect.
- R5: With depthSel=1, pixOut = {17'b0, R[7:3], G[7:3], B[7:3]}.
- R6: With depthSel=2, pixOut = {16'b0, R[7:3], G[7:2], B[7:3]}.
- R7: With depthSel=3, pixOut = {8'b0, R, G, B}.
- R8: With bgrOrder=1 and depthSel of 1, 2 or 3, the red and blue fields trade places in the formats of R5 to R7. The green field stays where it is.
- R9: invalidate is high for exactly the one cycle that follows each clock edge on which a word-1 write was taken, and is low otherwise.
- R10: The register word is regAddr[11:2], and the byte offset regAddr[1:0] is ignored. A write to any word other than 0 or 1 changes neither the pointer, the phase nor the palette.
- R11: Reset sets the entry pointer to 0, sets the phase to red and clears every component of every entry to zero.
- R12: pixOut follows pixIdx, depthSel and bgrOrder combinationally. A newly stored component is visible on pixOut right after the edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 12 | Register byte address |
| regWrData | input | 32 | Register write data |
| depthSel | input | 2 | Pixel format: 0 = 8-bit, 1 = 15-bit, 2 = 16-bit, 3 = 32-bit |
| bgrOrder | input | 1 | Swap the red and blue fields in the packed pixel |
| pixIdx | input | 8 | Palette index for the pixel lookup |
| pixOut | output | 32 | Packed pixel for the entry at pixIdx |
| invalidate | output | 1 | One-cycle full-screen redraw request |

## Verification
The bench starts with a full read-out of a freshly reset palette. This sweep separates a working clear from leftover or uninitialised entries. Directed sequences then check the following:
- A pointer reload in mid-triplet, which tells phase reset apart from phase carry-over.
- A write stream across entry 255, which tells modulo wrap apart from saturation.
- Writes to unused words and to odd byte offsets, which tell word decoding apart from full-address decoding.

Sixteen entries with distinct colours are then read in every depth and order combination. Because the colours differ per field, any field misplacement, truncation or swap error shows up as a wrong pixel value. A long random mix of register writes and lookups, compared against the reference model on every clock, covers back-to-back writes and the invalidate timing.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int COMP_W = 8;
  localparam int IDX_W  = 8;
  localparam int NCOMP  = 3;

  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    FMT_8  = 2'd0,
    FMT_15 = 2'd1,
    FMT_16 = 2'd2,
    FMT_32 = 2'd3
  } fmt_e;

  // Strobes from the write sequencer to the palette storage
  typedef struct packed {
    logic              wrEn;
    phase_e            comp;
    logic [IDX_W-1:0]  idx;
    logic [COMP_W-1:0] val;
  } pal_stb_t;
endpackage

// File: rtl/pal_ctrl.sv
module pal_ctrl
  import pal_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output pal_stb_t          stb,
  output logic [IDX_W-1:0]  curIdx,
  output phase_e            curPhase,
  output logic              invalidate
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] wordSel;
  logic              selIdx;
  logic              selData;
  logic [IDX_W-1:0]  fieldIdx;
  logic [COMP_W-1:0] fieldComp;
  logic              unusedBits;

  assign wordSel    = regAddr[ADDR_W-1:2];
  assign selIdx     = regWrEn && (wordSel == WORD_W'(0));
  assign selData    = regWrEn && (wordSel == WORD_W'(1));
  assign fieldIdx   = regWrData[DATA_W-1 -: IDX_W];
  assign fieldComp  = regWrData[DATA_W-1 -: COMP_W];
  assign unusedBits = ^{regAddr[1:0], regWrData[DATA_W-COMP_W-1:0]};

  always_comb begin
    stb.wrEn = selData;
    stb.comp = curPhase;
    stb.idx  = curIdx;
    stb.val  = fieldComp;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curIdx   <= '0;
      curPhase <= PH_RED;
    end else if (selIdx) begin
      curIdx   <= fieldIdx;
      curPhase <= PH_RED;
    end else if (selData) begin
      unique case (curPhase)
        PH_RED:  curPhase <= PH_GRN;
        PH_GRN:  curPhase <= PH_BLU;
        default: begin
          curPhase <= PH_RED;
          curIdx   <= IDX_W'(curIdx + 1'b1);
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) invalidate <= 1'b0;
    else       invalidate <= selData;
  end
endmodule

// File: rtl/pal_store.sv
module pal_store
  import pal_pkg::*;
#(
  parameter int ENTRIES = 256
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  pal_stb_t                    stb,
  input  logic [IDX_W-1:0]            rdIdx,
  output logic [NCOMP-1:0][COMP_W-1:0] rdEntry
);
  for (genvar c = 0; c < NCOMP; c++) begin : g_plane
    logic [COMP_W-1:0] mem [ENTRIES];
    logic              hit;

    assign hit = stb.wrEn && (stb.comp == phase_e'(c));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int e = 0; e < ENTRIES; e++) mem[e] <= '0;
      end else if (hit) begin
        mem[stb.idx] <= stb.val;
      end
    end

    assign rdEntry[c] = mem[rdIdx];
  end
endmodule

// File: rtl/pal_pack.sv
module pal_pack
  import pal_pkg::*;
#(
  parameter int PIX_W = 32
) (
  input  logic [NCOMP-1:0][COMP_W-1:0] entry,
  input  fmt_e                         fmt,
  input  logic                         bgr,
  output logic [PIX_W-1:0]             pix
);
  logic [COMP_W-1:0] red, grn, blu, hiC, loC;

  assign red = entry[0];
  assign grn = entry[1];
  assign blu = entry[2];
  assign hiC = bgr ? blu : red;
  assign loC = bgr ? red : blu;

  always_comb begin
    unique case (fmt)
      FMT_8:   pix = PIX_W'({red[COMP_W-1 -: 3], grn[COMP_W-1 -: 3], blu[COMP_W-1 -: 2]});
      FMT_15:  pix = PIX_W'({hiC[COMP_W-1 -: 5], grn[COMP_W-1 -: 5], loC[COMP_W-1 -: 5]});
      FMT_16:  pix = PIX_W'({hiC[COMP_W-1 -: 5], grn[COMP_W-1 -: 6], loC[COMP_W-1 -: 5]});
      default: pix = PIX_W'({hiC, grn, loC});
    endcase
  end
endmodule

// File: rtl/pal_lut_top.sv
module pal_lut_top
  import pal_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int PIX_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [1:0]        depthSel,
  input  logic              bgrOrder,
  input  logic [IDX_W-1:0]  pixIdx,
  output logic [PIX_W-1:0]  pixOut,
  output logic              invalidate
);
  localparam int ENTRIES = 1 << IDX_W;

  pal_stb_t                     stb;
  logic [IDX_W-1:0]             curIdx;
  phase_e                       curPhase;
  logic [NCOMP-1:0][COMP_W-1:0] rdEntry;

  pal_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .stb        (stb),
    .curIdx     (curIdx),
    .curPhase   (curPhase),
    .invalidate (invalidate)
  );

  pal_store #(.ENTRIES(ENTRIES)) store_i (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .rdIdx   (pixIdx),
    .rdEntry (rdEntry)
  );

  pal_pack #(.PIX_W(PIX_W)) pack_i (
    .entry (rdEntry),
    .fmt   (fmt_e'(depthSel)),
    .bgr   (bgrOrder),
    .pix   (pixOut)
  );
endmodule

// File: rtl/pal_lut_chk.sv
module pal_lut_chk
  import pal_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int PIX_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWrData,
  input logic [1:0]        depthSel,
  input logic [PIX_W-1:0]  pixOut,
  input logic              invalidate,
  input logic [IDX_W-1:0]  curIdx,
  input phase_e            curPhase
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] wordSel;
  logic wrIdx, wrData, wrOther;

  assign wordSel = regAddr[ADDR_W-1:2];
  assign wrIdx   = regWrEn && (wordSel == WORD_W'(0));
  assign wrData  = regWrEn && (wordSel == WORD_W'(1));
  assign wrOther = regWrEn && (wordSel > WORD_W'(1));

  p_idx_load_r1: assert property (@(posedge clk) disable iff (!rstN)
    wrIdx |=> (curIdx == $past(regWrData[DATA_W-1 -: IDX_W])) && (curPhase == PH_RED));

  p_phase_adv_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrData && curPhase == PH_RED) |=> (curPhase == PH_GRN) && $stable(curIdx));

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrData && curPhase == PH_BLU) |=>
      (curPhase == PH_RED) && (curIdx == IDX_W'($past(curIdx) + 1'b1)));

  p_narrow_r4: assert property (@(posedge clk) disable iff (!rstN)
    (depthSel == 2'd0) |-> (pixOut[PIX_W-1:8] == '0));

  p_top_byte_r7: assert property (@(posedge clk) disable iff (!rstN)
    (depthSel == 2'd3) |-> (pixOut[PIX_W-1:24] == '0));

  p_inval_r9: assert property (@(posedge clk) disable iff (!rstN)
    wrData |=> invalidate);

  p_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !wrData |=> !invalidate);

  p_ignore_r10: assert property (@(posedge clk) disable iff (!rstN)
    wrOther |=> $stable(curIdx) && $stable(curPhase));
endmodule

bind pal_lut_top pal_lut_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PIX_W(PIX_W)) chk_i (.*);

// File: tb/pal_lut_top_tb_top.sv
module pal_lut_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        regWrEn;
  logic [11:0] regAddr;
  logic [31:0] regWrData;
  logic [1:0]  depthSel;
  logic        bgrOrder;
  logic [7:0]  pixIdx;
  logic [31:0] pixOut;
  logic        invalidate;

  int    vectors = 0;
  int    miscompares = 0;
  bit    done = 1'b0;
  string phaseTag = "R11";

  int mR[256];
  int mG[256];
  int mB[256];
  int mIdx;
  int mPh;
  bit mInval;

  always #2 clk = ~clk;

  pal_lut_top dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .depthSel(depthSel), .bgrOrder(bgrOrder),
    .pixIdx(pixIdx), .pixOut(pixOut), .invalidate(invalidate)
  );

  function automatic int expPix(int p, int d, bit s);
    int r, g, b, hi, lo;
    r = mR[p]; g = mG[p]; b = mB[p];
    hi = s ? b : r;
    lo = s ? r : b;
    case (d)
      0:       return ((r >> 5) << 5) | ((g >> 5) << 2) | (b >> 6);
      1:       return ((hi >> 3) << 10) | ((g >> 3) << 5) | (lo >> 3);
      2:       return ((hi >> 3) << 11) | ((g >> 2) << 5) | (lo >> 3);
      default: return (hi << 16) | (g << 8) | lo;
    endcase
  endfunction

  function automatic string fmtTag(int d, bit s);
    if (s && d != 0) return "R8";
    case (d)
      0:       return "R4";
      1:       return "R5";
      2:       return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic checkOutputs();
    cmp($sformatf("%s/%s/R12 pixOut idx %0d", phaseTag, fmtTag(depthSel, bgrOrder), pixIdx),
        pixOut, 32'(expPix(pixIdx, depthSel, bgrOrder)));
    cmp($sformatf("%s/R9 invalidate", phaseTag), 32'(invalidate), 32'(mInval));
  endtask

  task automatic step(bit we, logic [11:0] a, logic [31:0] d, logic [1:0] ds, bit bo, logic [7:0] pi);
    int w;
    regWrEn = we; regAddr = a; regWrData = d;
    depthSel = ds; bgrOrder = bo; pixIdx = pi;
    @(posedge clk);
    mInval = 1'b0;
    w = int'(a >> 2);
    if (we && w == 0) begin
      mIdx = int'(d[31:24]);
      mPh  = 0;
    end else if (we && w == 1) begin
      case (mPh)
        0:       mR[mIdx] = int'(d[31:24]);
        1:       mG[mIdx] = int'(d[31:24]);
        default: mB[mIdx] = int'(d[31:24]);
      endcase
      mInval = 1'b1;
      if (mPh == 2) begin
        mPh  = 0;
        mIdx = (mIdx + 1) % 256;
      end else begin
        mPh++;
      end
    end
    @(negedge clk);
    checkOutputs();
  endtask

  task automatic setIdx(int i, logic [7:0] pi);
    step(1'b1, 12'h000, {8'(i), 24'h5A5A5A}, 2'd3, 1'b0, pi);
  endtask

  task automatic putComp(int v, logic [7:0] pi);
    step(1'b1, 12'h004, {8'(v), 24'($urandom)}, 2'd3, 1'b0, pi);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin mR[i] = 0; mG[i] = 0; mB[i] = 0; end
    mIdx = 0; mPh = 0; mInval = 1'b0;
    rstN = 1'b0; regWrEn = 1'b0; regAddr = '0; regWrData = '0;
    depthSel = 2'd3; bgrOrder = 1'b0; pixIdx = '0;
    repeat (3) @(negedge clk);
    cmp("R11 invalidate in reset", 32'(invalidate), 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R11: every entry reads zero after reset
    phaseTag = "R11";
    for (int i = 0; i < 256; i++) step(1'b0, 12'h000, '0, 2'd3, 1'b0, 8'(i));

    // R1 R2: pointer load then component order, junk in low data bits
    phaseTag = "R1R2";
    setIdx(5, 8'd5);
    putComp(8'hC3, 8'd5);
    putComp(8'h81, 8'd5);
    putComp(8'h3E, 8'd5);
    step(1'b0, 12'h000, '0, 2'd3, 1'b1, 8'd5);
    // R1: pointer reload mid-triplet resets phase to red
    setIdx(10, 8'd10);
    putComp(8'h11, 8'd10);
    putComp(8'h22, 8'd10);
    setIdx(20, 8'd20);
    putComp(8'h99, 8'd20);
    step(1'b0, 12'h000, '0, 2'd3, 1'b0, 8'd10);
    step(1'b0, 12'h000, '0, 2'd3, 1'b0, 8'd20);

    // R3: stream crosses entry 255 into entry 0
    phaseTag = "R3";
    setIdx(255, 8'd255);
    putComp(8'hF0, 8'd255);
    putComp(8'h0F, 8'd255);
    putComp(8'hAA, 8'd255);
    putComp(8'h77, 8'd0);
    putComp(8'h66, 8'd0);
    putComp(8'h55, 8'd0);
    step(1'b0, 12'h000, '0, 2'd3, 1'b0, 8'd1);

    // R10: unused words ignored, byte offset ignored
    phaseTag = "R10";
    setIdx(30, 8'd30);
    putComp(8'h12, 8'd30);
    step(1'b1, 12'h008, 32'hFF00_0000, 2'd3, 1'b0, 8'd30);
    step(1'b1, 12'hFFC, 32'h0100_0000, 2'd3, 1'b0, 8'd30);
    step(1'b1, 12'h00C, 32'h0200_0000, 2'd3, 1'b0, 8'd30);
    step(1'b1, 12'h007, 32'h3400_0000, 2'd3, 1'b0, 8'd30);
    step(1'b1, 12'h005, 32'h5600_0000, 2'd3, 1'b0, 8'd30);
    step(1'b1, 12'h003, 32'h2000_0000, 2'd3, 1'b0, 8'd31);
    step(1'b1, 12'h006, 32'h4400_0000, 2'd3, 1'b0, 8'd32);

    // R4-R8: distinct colours read in every format and order
    phaseTag = "FMT";
    setIdx(64, 8'd64);
    for (int i = 0; i < 48; i++) putComp(int'($urandom_range(0, 255)), 8'(64 + i / 3));
    for (int d = 0; d < 4; d++)
      for (int s = 0; s < 2; s++)
        for (int e = 64; e < 80; e++) step(1'b0, 12'h000, '0, 2'(d), 1'(s), 8'(e));

    // R12: random mix, compared every clock
    phaseTag = "RND";
    for (int n = 0; n < 4000; n++) begin
      logic [11:0] a;
      if ($urandom_range(0, 7) == 0) a = 12'($urandom);
      else a = {9'd0, 1'($urandom_range(0, 1)), 2'($urandom)};
      if ($urandom_range(0, 3) == 0) a[11:2] = 10'd0;
      step(1'($urandom_range(0, 1)), a,
           {3'd0, 29'($urandom)} | {8'($urandom_range(0, 255)) & 8'h07, 24'h0} | 32'($urandom),
           2'($urandom), 1'($urandom), 8'($urandom_range(0, 7)));
    end

    // Final read-out of the whole palette
    phaseTag = "R12";
    for (int i = 0; i < 256; i++) step(1'b0, 12'h000, '0, 2'(i % 4), 1'(i / 4 % 2), 8'(i));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule